// File: doc/BRIEF.md
# Priority Interrupt Resolver with Mask

This block picks one interrupt out of a set of pending requests and presents it to the processor. The sources are a single non-maskable request, six external IRQ channels and a parameterised number of peripheral request lines. Each maskable source has a 4-bit priority field, written over a small write-only register bus. The non-maskable source sits at a fixed level of 16, above every programmable level. A maskable source whose field holds 0 is switched off. The processor supplies its current 4-bit mask level as an input. Stacking, vector fetch and the processor status register stay outside the block.

Every cycle a combinational selector finds the best eligible source. A small state machine registers that choice, so the request, source ID and level change one cycle after the inputs do. The machine has three states. ST_IDLE means no request is presented. ST_PEND means a request is presented. ST_GRANT is a single cycle after the processor accepts, during which the new mask value to load is shown.

The transitions are as follows. ST_IDLE goes to ST_PEND when a candidate exists and otherwise stays in ST_IDLE. ST_PEND goes to ST_GRANT on an accept. Without an accept, ST_PEND stays in ST_PEND while a candidate exists and falls back to ST_IDLE when none does. ST_GRANT always returns to ST_IDLE.

Top module: `prio_resolver`

## Requirements
- R1: After reset, `irq_req` and `new_mask_vld` are 0 and every priority field is 0. Pending maskable requests therefore raise no request until a field is written.
- R2: A maskable source whose field is 0 is never requested, whatever the mask, and `irq_lvl` is never 0 while `irq_req` is 1.
- R3: A maskable source is eligible only when it is pending and its field is strictly greater than `cur_mask`.
- R4: A pending non-maskable request (`nmi_pend`) is presented as source ID 0 at level 16. This holds even when `cur_mask` is 15, and it wins over every other source.
- R5: Among eligible sources, the one with the highest level is presented.
- R6: Source IDs are numbered as follows: 0 is the non-maskable source, 1 to 6 are IRQ channels 0 to 5, and 7 onwards are peripheral lines 0 onwards. When eligible sources share the top level, the lowest ID wins.
- R7: `irq_req`, `irq_id` and `irq_lvl` are registered. A change of the inputs shows at the outputs after the next rising clock edge and not before.
- R8: When `cpu_ack` is 1 while `irq_req` is 1, the next cycle has `irq_req` 0 and `new_mask_vld` 1 for exactly one cycle, with `irq_id` and `irq_lvl` held. The cycle after that has `new_mask_vld` 0 and `irq_req` 0.
- R9: During `new_mask_vld`, `new_mask` is 15 for source ID 0. For any other source it is the winner's programmed level.
- R10: A write with `wr_en` 1 loads `wr_data` into the field chosen by `wr_sel`. Selector values 0 to 5 pick IRQ channels 0 to 5, and 6 onwards pick peripheral lines. A selector at or above the number of maskable sources changes no field.
- R11: `cpu_ack` while `irq_req` is 0 has no effect, and `new_mask_vld` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_pend | input | 1 | Non-maskable request pending |
| irq_pend | input | N_IRQ (6) | External IRQ channel requests pending |
| per_pend | input | N_PER (2) | Peripheral requests pending |
| cur_mask | input | LVL_W (4) | Current processor mask level |
| wr_en | input | 1 | Priority field write strobe |
| wr_sel | input | ID_W (4) | Index of the field to write |
| wr_data | input | LVL_W (4) | Level to write |
| cpu_ack | input | 1 | Processor accepts the presented request |
| irq_req | output | 1 | Request presented to the processor |
| irq_id | output | ID_W (4) | Source ID of the presented request |
| irq_lvl | output | LVL_W+1 (5) | Level of the presented request (1 to 16) |
| new_mask_vld | output | 1 | New mask value is valid (one cycle) |
| new_mask | output | LVL_W (4) | Mask level to load on acceptance |

## Verification
The assertions check several properties on every cycle. A presented maskable level must lie above the mask of the previous cycle, and a presented level is never zero. The non-maskable source must always be shown at level 16 one cycle after it is pending. An accept must lead to exactly one grant cycle with the held ID and the correct new mask, and a stray acknowledge must never produce a grant. Some behaviour depends on programmed field contents, and only the bench's scenarios can show it. This covers which source wins among several levels, the lowest-ID tie-break, a zero field disabling a source, and out-of-range writes leaving fields intact. The bench also checks the exact cycle at which outputs follow inputs.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_GRANT = 2'd2
    } res_state_e;
endpackage

// File: rtl/prio_level_regs.sv
module prio_level_regs #(
    parameter int unsigned NSRC_M = 8,
    parameter int unsigned LVL_W  = 4,
    parameter int unsigned SEL_W  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [SEL_W-1:0]                  wr_sel,
    input  logic [LVL_W-1:0]                  wr_data,
    output logic [NSRC_M-1:0][LVL_W-1:0]      lvl_q
);
    // One field per maskable source; a selector outside the range hits none (R10)
    for (genvar i = 0; i < NSRC_M; i++) begin : g_field
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q[i] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(i))) begin
                lvl_q[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/prio_select.sv
module prio_select #(
    parameter int unsigned NSRC_M = 8,
    parameter int unsigned LVL_W  = 4,
    parameter int unsigned ID_W   = 4
) (
    input  logic                          nmi_pend,
    input  logic [NSRC_M-1:0]             req,
    input  logic [NSRC_M-1:0][LVL_W-1:0]  lvl,
    input  logic [LVL_W-1:0]              cur_mask,
    output logic                          cand_vld,
    output logic [ID_W-1:0]               cand_id,
    output logic [LVL_W:0]                cand_lvl
);
    localparam logic [LVL_W:0] TOP_LVL = (LVL_W+1)'(1) << LVL_W;

    logic [NSRC_M-1:0] elig;

    // R2/R3: pending, non-zero and strictly above the current mask
    for (genvar i = 0; i < NSRC_M; i++) begin : g_elig
        assign elig[i] = req[i] && (lvl[i] != '0) && (lvl[i] > cur_mask);
    end

    // Ascending scan with strict compare: lowest ID keeps ties (R6)
    always_comb begin
        cand_vld = nmi_pend;
        cand_id  = '0;
        cand_lvl = nmi_pend ? TOP_LVL : '0;
        for (int i = 0; i < NSRC_M; i++) begin
            if (elig[i] && ({1'b0, lvl[i]} > cand_lvl)) begin
                cand_vld = 1'b1;
                cand_id  = ID_W'(i + 1);
                cand_lvl = {1'b0, lvl[i]};
            end
        end
    end
endmodule

// File: rtl/prio_ctrl.sv
module prio_ctrl
    import prio_res_pkg::*;
#(
    parameter int unsigned LVL_W = 4,
    parameter int unsigned ID_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_vld,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [LVL_W:0]    cand_lvl,
    input  logic              cpu_ack,
    output logic              irq_req,
    output logic [ID_W-1:0]   irq_id,
    output logic [LVL_W:0]    irq_lvl,
    output logic              new_mask_vld,
    output logic [LVL_W-1:0]  new_mask
);
    res_state_e state_q, state_d;
    logic       accept;

    assign accept = (state_q == ST_PEND) && cpu_ack;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = cand_vld ? ST_PEND : ST_IDLE;
            ST_PEND:  state_d = cpu_ack ? ST_GRANT : (cand_vld ? ST_PEND : ST_IDLE);
            ST_GRANT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs: winner follows the selector except across a grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_id   <= '0;
            irq_lvl  <= '0;
            new_mask <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_PEND: begin
                    if (accept) begin
                        new_mask <= (irq_id == '0) ? '1 : irq_lvl[LVL_W-1:0];
                    end else begin
                        irq_id  <= cand_id;
                        irq_lvl <= cand_lvl;
                    end
                end
                ST_GRANT: begin
                    irq_id  <= irq_id;
                    irq_lvl <= irq_lvl;
                end
                default: begin
                    irq_id  <= '0;
                    irq_lvl <= '0;
                end
            endcase
        end
    end

    assign irq_req      = (state_q == ST_PEND);
    assign new_mask_vld = (state_q == ST_GRANT);
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver #(
    parameter int unsigned N_IRQ = 6,
    parameter int unsigned N_PER = 2,
    parameter int unsigned LVL_W = 4,
    localparam int unsigned NSRC_M = N_IRQ + N_PER,
    localparam int unsigned ID_W   = $clog2(NSRC_M + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pend,
    input  logic [N_IRQ-1:0]  irq_pend,
    input  logic [N_PER-1:0]  per_pend,
    input  logic [LVL_W-1:0]  cur_mask,
    input  logic              wr_en,
    input  logic [ID_W-1:0]   wr_sel,
    input  logic [LVL_W-1:0]  wr_data,
    input  logic              cpu_ack,
    output logic              irq_req,
    output logic [ID_W-1:0]   irq_id,
    output logic [LVL_W:0]    irq_lvl,
    output logic              new_mask_vld,
    output logic [LVL_W-1:0]  new_mask
);
    logic [NSRC_M-1:0][LVL_W-1:0] lvl_q;
    logic [NSRC_M-1:0]            req_m;
    logic                         cand_vld;
    logic [ID_W-1:0]              cand_id;
    logic [LVL_W:0]               cand_lvl;

    // Maskable order: IRQ channels first, then peripherals (R6)
    assign req_m = {per_pend, irq_pend};

    prio_level_regs #(.NSRC_M(NSRC_M), .LVL_W(LVL_W), .SEL_W(ID_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .lvl_q   (lvl_q)
    );

    prio_select #(.NSRC_M(NSRC_M), .LVL_W(LVL_W), .ID_W(ID_W)) u_sel (
        .nmi_pend (nmi_pend),
        .req      (req_m),
        .lvl      (lvl_q),
        .cur_mask (cur_mask),
        .cand_vld (cand_vld),
        .cand_id  (cand_id),
        .cand_lvl (cand_lvl)
    );

    prio_ctrl #(.LVL_W(LVL_W), .ID_W(ID_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cand_vld     (cand_vld),
        .cand_id      (cand_id),
        .cand_lvl     (cand_lvl),
        .cpu_ack      (cpu_ack),
        .irq_req      (irq_req),
        .irq_id       (irq_id),
        .irq_lvl      (irq_lvl),
        .new_mask_vld (new_mask_vld),
        .new_mask     (new_mask)
    );
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
    parameter int unsigned LVL_W = 4,
    parameter int unsigned ID_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nmi_pend,
    input logic [LVL_W-1:0]  cur_mask,
    input logic              cpu_ack,
    input logic              irq_req,
    input logic [ID_W-1:0]   irq_id,
    input logic [LVL_W:0]    irq_lvl,
    input logic              new_mask_vld,
    input logic [LVL_W-1:0]  new_mask
);
    localparam logic [LVL_W:0] TOP_LVL = (LVL_W+1)'(1) << LVL_W;

    p_nonzero_lvl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl != '0));

    p_above_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_id != '0) |-> ({1'b0, $past(cur_mask)} < irq_lvl));

    p_nmi_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_id == '0) |-> (irq_lvl == TOP_LVL));

    p_nmi_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !new_mask_vld && !(irq_req && cpu_ack)) |=> (irq_req && irq_id == '0));

    p_grant_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && cpu_ack) |=> (new_mask_vld && !irq_req && $stable(irq_id) && $stable(irq_lvl)));

    p_grant_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        new_mask_vld |=> (!new_mask_vld && !irq_req));

    p_new_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        new_mask_vld |-> (new_mask == ((irq_id == '0) ? {LVL_W{1'b1}} : irq_lvl[LVL_W-1:0])));

    p_stray_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |=> !new_mask_vld);
endmodule

bind prio_resolver prio_resolver_chk #(.LVL_W(LVL_W), .ID_W(ID_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .nmi_pend     (nmi_pend),
    .cur_mask     (cur_mask),
    .cpu_ack      (cpu_ack),
    .irq_req      (irq_req),
    .irq_id       (irq_id),
    .irq_lvl      (irq_lvl),
    .new_mask_vld (new_mask_vld),
    .new_mask     (new_mask)
);

// File: tb/prio_resolver_bench.sv
`timescale 1ns/1ps
module prio_resolver_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_pend = 1'b0;
    logic [5:0] irq_pend = '0;
    logic [1:0] per_pend = '0;
    logic [3:0] cur_mask = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_sel = '0;
    logic [3:0] wr_data = '0;
    logic       cpu_ack = 1'b0;
    logic       irq_req;
    logic [3:0] irq_id;
    logic [4:0] irq_lvl;
    logic       new_mask_vld;
    logic [3:0] new_mask;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prio_resolver u_prio_resolver (
        .clk(clk), .rst_n(rst_n), .nmi_pend(nmi_pend), .irq_pend(irq_pend),
        .per_pend(per_pend), .cur_mask(cur_mask), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cpu_ack(cpu_ack), .irq_req(irq_req), .irq_id(irq_id),
        .irq_lvl(irq_lvl), .new_mask_vld(new_mask_vld), .new_mask(new_mask)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_lvl(int sel, int data);
        wr_en = 1'b1; wr_sel = 4'(sel); wr_data = 4'(data);
        step();
        wr_en = 1'b0;
    endtask

    task automatic clear_pend();
        nmi_pend = 1'b0; irq_pend = '0; per_pend = '0; cur_mask = '0;
        step();
        step();
    endtask

    task automatic t_reset();
        check("R1 req after reset", int'(irq_req), 0);
        check("R1 grant after reset", int'(new_mask_vld), 0);
        irq_pend = '1; per_pend = '1;
        step(); step();
        check("R1 R2 no req with zero fields", int'(irq_req), 0);
        clear_pend();
    endtask

    task automatic t_write();
        write_lvl(0, 3); write_lvl(1, 7); write_lvl(2, 7); write_lvl(3, 0);
        write_lvl(4, 2); write_lvl(5, 9); write_lvl(6, 12); write_lvl(7, 5);
        write_lvl(15, 15);
        write_lvl(8, 14);
        per_pend = 2'b10;
        step();
        check("R10 per1 req", int'(irq_req), 1);
        check("R10 per1 id", int'(irq_id), 8);
        check("R10 out-of-range write ignored lvl", int'(irq_lvl), 5);
        clear_pend();
    endtask

    task automatic t_mask();
        irq_pend = 6'b000010; cur_mask = 4'd6;
        step();
        check("R3 lvl7 over mask6 req", int'(irq_req), 1);
        check("R3 lvl7 id", int'(irq_id), 2);
        cur_mask = 4'd7;
        step();
        check("R3 lvl7 at mask7 blocked", int'(irq_req), 0);
        clear_pend();
    endtask

    task automatic t_zero();
        irq_pend = 6'b001000;
        step(); step();
        check("R2 zero field never requested", int'(irq_req), 0);
        clear_pend();
    endtask

    task automatic t_prio();
        irq_pend = 6'b100001; per_pend = 2'b01;
        step();
        check("R5 highest id", int'(irq_id), 7);
        check("R5 highest lvl", int'(irq_lvl), 12);
        per_pend = 2'b00;
        step();
        check("R5 next highest id", int'(irq_id), 6);
        clear_pend();
    endtask

    task automatic t_tie();
        irq_pend = 6'b000110;
        step();
        check("R6 tie lowest id", int'(irq_id), 2);
        check("R6 tie lvl", int'(irq_lvl), 7);
        clear_pend();
    endtask

    task automatic t_nmi();
        nmi_pend = 1'b1; per_pend = 2'b01; cur_mask = 4'd15;
        step();
        check("R4 nmi req at mask15", int'(irq_req), 1);
        check("R4 nmi id", int'(irq_id), 0);
        check("R4 nmi lvl", int'(irq_lvl), 16);
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
        check("R8 nmi grant", int'(new_mask_vld), 1);
        check("R9 nmi new mask", int'(new_mask), 15);
        nmi_pend = 1'b0; per_pend = '0;
        clear_pend();
    endtask

    task automatic t_timing();
        irq_pend = 6'b100000;
        #2;
        check("R7 no change before edge", int'(irq_req), 0);
        step();
        check("R7 req after edge", int'(irq_req), 1);
        irq_pend = '0;
        #2;
        check("R7 req held before edge", int'(irq_req), 1);
        step();
        check("R7 req drops after edge", int'(irq_req), 0);
        clear_pend();
    endtask

    task automatic t_accept();
        irq_pend = 6'b100000;
        step();
        check("R8 req before ack", int'(irq_req), 1);
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
        check("R8 req low in grant", int'(irq_req), 0);
        check("R8 grant valid", int'(new_mask_vld), 1);
        check("R8 id held", int'(irq_id), 6);
        check("R9 new mask is level", int'(new_mask), 9);
        step();
        check("R8 grant single cycle", int'(new_mask_vld), 0);
        check("R8 req low after grant", int'(irq_req), 0);
        clear_pend();
    endtask

    task automatic t_stray();
        cpu_ack = 1'b1;
        step();
        check("R11 stray ack no grant", int'(new_mask_vld), 0);
        step();
        check("R11 stray ack no grant 2", int'(new_mask_vld), 0);
        cpu_ack = 1'b0;
        step();
    endtask

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_write();
        t_mask();
        t_zero();
        t_prio();
        t_tie();
        t_nmi();
        t_timing();
        t_accept();
        t_stray();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule